// File: doc/BRIEF.md
# Two-Stage Fractional Clock-Enable Divider

This block thins a stream of input enable pulses into a slower stream of single-cycle output strobes. Two divider stages are placed in series. A pre-divider comes first and can be switched off or left out at build time. A downstream divider always follows it. Each stage reads its divisor from a bit field inside a 32-bit register word. The field holds the divisor minus one. Its low-order bits may be a binary fraction, in which case the minus-one offset applies only to the integer bits above them.

Non-integer ratios come from a phase accumulator, so the long-run average output rate equals the programmed ratio exactly. Both stages are combinational in the pulse path, and the final strobe is registered once. Either stage can instead be built as a fixed divider with a constant integer divisor and no register field.

Top module: `cdiv_two_stage`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_en` is 0. Reset also clears both stage phases.
- R2: A stage's field is `reg[LSB+W-1:LSB]`. Bits `[F-1:0]` of the field are the fraction in units of 2^-F, and bits `[W-1:F]` are the integer part minus one. The scaled divisor is therefore field + 2^F.
- R3: A variable stage adds 2^F to its phase on every input pulse. It emits a pulse when the phase reaches the scaled divisor, and that divisor is then subtracted from the phase. Starting from phase 0, S input pulses yield exactly 2^F output pulses.
- R4: A field value of 0 (divisor 1.0) forwards every input pulse.
- R5: When `pre_en` is 1, the pre-divider output drives the downstream stage, so the overall ratio is the product of the two divisors.
- R6: When `pre_en` is 0, the pre-divider forwards `in_en` unchanged and its phase is held at 0.
- R7: A field value that differs from the one seen in the previous cycle restarts that stage's phase at 0 in the same cycle, before that cycle's input pulse is counted.
- R8: `out_en` rises in the cycle after the input pulse that produced it, and is never 1 unless `in_en` was 1 in the previous cycle.
- R9: A stage built with a nonzero fixed divisor N emits one pulse per N input pulses and ignores its register word.
- R10: Register bits outside a stage's field have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Input enable pulse stream |
| pre_en | input | 1 | 1 = pre-divider active, 0 = pre-divider bypassed |
| pre_reg | input | 32 | Register word holding the pre-divider field |
| main_reg | input | 32 | Register word holding the downstream divider field |
| out_en | output | 1 | Divided single-cycle enable strobe |

## Verification
The sharpest collision is a divisor rewrite landing in the same cycle as an input pulse. That pulse must be counted against the new divisor from a phase of zero, not against the old phase. A long random phase provokes it by changing one field or the other at random, while `in_en` is high most of the time and `pre_en` toggles, which also makes a bypass switch coincide with pulses. A behavioural model, built from the restart and accumulate rules alone, predicts `out_en` every cycle and judges each cycle against the design.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int REG_W = 32;
  typedef logic [REG_W-1:0] cdiv_word_t;
endpackage

// File: rtl/cdiv_frac_stage.sv
module cdiv_frac_stage #(
  parameter int W = 8,
  parameter int F = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] field,
  input  logic         bypass,
  input  logic         in_pulse,
  output logic         out_pulse
);
  localparam int AW = W + 2;
  localparam logic [AW-1:0] ONE = AW'(1) << F;

  logic [W-1:0]  held_q;
  logic [AW-1:0] acc_q, acc_d, eff, sum, scaled;
  logic          changed, hit;

  always_comb begin
    scaled  = AW'(field) + ONE;
    changed = (field != held_q);
    eff     = changed ? '0 : acc_q;
    sum     = eff + ONE;
    hit     = in_pulse && (sum >= scaled);
    if (bypass)        acc_d = '0;
    else if (!in_pulse) acc_d = eff;
    else if (hit)      acc_d = sum - scaled;
    else               acc_d = sum;
    out_pulse = bypass ? in_pulse : hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      acc_q  <= '0;
    end else begin
      held_q <= field;
      acc_q  <= acc_d;
    end
  end

  AST_PHASE_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < (AW'(held_q) + ONE)); // R3
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && field == '0 && in_pulse) |-> out_pulse); // R4
  AST_PULSE_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> in_pulse); // R3
  AST_BYPASS_PHASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bypass) |-> acc_q == '0); // R6
endmodule

// File: rtl/cdiv_fixed_stage.sv
module cdiv_fixed_stage #(
  parameter int DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic in_pulse,
  output logic out_pulse
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap      = in_pulse && (cnt_q == LAST);
  assign out_pulse = bypass ? in_pulse : wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (bypass)   cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else if (in_pulse) cnt_q <= cnt_q + 1'b1;
  end

  AST_FIXED_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R9
endmodule

// File: rtl/cdiv_stage.sv
module cdiv_stage
  import cdiv_pkg::*;
#(
  parameter int FIXED = 0,
  parameter int LSB   = 8,
  parameter int W     = 8,
  parameter int F     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cdiv_word_t reg_word,
  input  logic       bypass,
  input  logic       in_pulse,
  output logic       out_pulse
);
  generate
    if (FIXED != 0) begin : g_fixed
      cdiv_fixed_stage #(.DIV(FIXED)) u_fix (
        .clk(clk), .rst_n(rst_n), .bypass(bypass),
        .in_pulse(in_pulse), .out_pulse(out_pulse));
    end else begin : g_frac
      logic [W-1:0] field;
      assign field = reg_word[LSB +: W];
      cdiv_frac_stage #(.W(W), .F(F)) u_frac (
        .clk(clk), .rst_n(rst_n), .field(field), .bypass(bypass),
        .in_pulse(in_pulse), .out_pulse(out_pulse));
    end
  endgenerate
endmodule

// File: rtl/cdiv_two_stage.sv
module cdiv_two_stage
  import cdiv_pkg::*;
#(
  parameter int PRE_PRESENT = 1,
  parameter int PRE_FIXED   = 0,
  parameter int PRE_LSB     = 4,
  parameter int PRE_W       = 6,
  parameter int PRE_FRAC    = 2,
  parameter int MAIN_FIXED  = 0,
  parameter int MAIN_LSB    = 8,
  parameter int MAIN_W      = 8,
  parameter int MAIN_FRAC   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_en,
  input  logic        pre_en,
  input  logic [31:0] pre_reg,
  input  logic [31:0] main_reg,
  output logic        out_en
);
  logic pre_pulse, main_pulse, out_q;

  generate
    if (PRE_PRESENT != 0) begin : g_pre
      cdiv_stage #(.FIXED(PRE_FIXED), .LSB(PRE_LSB), .W(PRE_W), .F(PRE_FRAC)) u_pre (
        .clk(clk), .rst_n(rst_n), .reg_word(pre_reg), .bypass(!pre_en),
        .in_pulse(in_en), .out_pulse(pre_pulse));
    end else begin : g_nopre
      assign pre_pulse = in_en;
    end
  endgenerate

  cdiv_stage #(.FIXED(MAIN_FIXED), .LSB(MAIN_LSB), .W(MAIN_W), .F(MAIN_FRAC)) u_main (
    .clk(clk), .rst_n(rst_n), .reg_word(main_reg), .bypass(1'b0),
    .in_pulse(pre_pulse), .out_pulse(main_pulse));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= main_pulse;
  end
  assign out_en = out_q;

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> $past(in_en)); // R8
  AST_PRE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |-> (pre_pulse == in_en)); // R6
  AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    main_pulse |-> pre_pulse); // R5
endmodule

// File: tb/test_cdiv_two_stage.sv
module test_cdiv_two_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_en = 1'b0;
  logic pre_en = 1'b0;
  logic [31:0] pre_reg = '0;
  logic [31:0] main_reg = '0;
  logic out_en, out_fix;

  int n_checks = 0;
  int n_fail = 0;
  int cnt_main = 0;
  int cnt_fix = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cdiv_two_stage i_cdiv_two_stage (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .pre_en(pre_en),
    .pre_reg(pre_reg), .main_reg(main_reg), .out_en(out_en));

  cdiv_two_stage #(.PRE_FIXED(3)) i_cdiv_two_stage_fix (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .pre_en(pre_en),
    .pre_reg(pre_reg), .main_reg(main_reg), .out_en(out_fix));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: scaled divisor = field + 2^F, phase restarts on field change.
  int m_pacc = 0, m_phold = 0, m_macc = 0, m_mhold = 0;
  bit m_exp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pacc = 0; m_phold = 0; m_macc = 0; m_mhold = 0; m_exp = 0;
    end else begin
      int pf, mf, s, e;
      bit pp, mp;
      pf = int'((pre_reg >> 4) & 32'h3f);
      mf = int'((main_reg >> 8) & 32'hff);
      if (!pre_en) begin
        pp = in_en; m_pacc = 0; m_phold = pf;
      end else begin
        s = pf + 4;
        e = (pf != m_phold) ? 0 : m_pacc;
        m_phold = pf;
        pp = 0;
        if (in_en) begin
          if (e + 4 >= s) begin pp = 1; m_pacc = e + 4 - s; end
          else m_pacc = e + 4;
        end else m_pacc = e;
      end
      s = mf + 8;
      e = (mf != m_mhold) ? 0 : m_macc;
      m_mhold = mf;
      mp = 0;
      if (pp) begin
        if (e + 8 >= s) begin mp = 1; m_macc = e + 8 - s; end
        else m_macc = e + 8;
      end else m_macc = e;
      m_exp = mp;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " per-cycle"}, int'(out_en), int'(m_exp));
      if (out_en) cnt_main++;
      if (out_fix) cnt_fix++;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_en = 1'b0;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", int'(out_en), 0);
    chk("R1 reset fixed", int'(out_fix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(out_en), 0);

    // R8: single pulse latency
    cur_req = "R8";
    idle(2);
    in_en = 1'b1;
    #1 chk("R8 before edge", int'(out_en), 0);
    @(negedge clk); in_en = 1'b0;
    chk("R8 one cycle later", int'(out_en), 1);
    @(negedge clk);
    chk("R8 single strobe", int'(out_en), 0);

    // R4: divisor 1.0 forwards every pulse
    cur_req = "R4";
    idle(2); cnt_main = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); in_en = (i % 2 == 0); end
    idle(3);
    chk("R4 unity pass count", cnt_main, 10);

    // R3/R2: field 10 with F=3 -> scaled 18 (2.25)
    cur_req = "R3";
    main_reg = 32'd10 << 8;
    idle(2); cnt_main = 0;
    for (int i = 0; i < 36; i++) begin @(negedge clk); in_en = 1'b1; end
    idle(3);
    chk("R3 fractional count 36/2.25", cnt_main, 16);
    chk("R2 field decode", cnt_main, 16);

    // R10: garbage outside the fields
    cur_req = "R10";
    main_reg = 32'd3 << 8; idle(2);
    main_reg = 32'd10 << 8; idle(2); cnt_main = 0;
    for (int i = 0; i < 36; i++) begin
      @(negedge clk);
      in_en = 1'b1;
      main_reg = (32'd10 << 8) | ($urandom & 32'hffff00ff);
      pre_reg = $urandom;
    end
    idle(3);
    chk("R10 outside bits ignored", cnt_main, 16);

    // R5/R9: pre 1.5 (field 2, F=2) then main 2.0 (field 8); fixed pre /3
    cur_req = "R5";
    pre_en = 1'b0; pre_reg = 32'd2 << 4; main_reg = 32'd8 << 8;
    idle(3); cnt_main = 0; cnt_fix = 0;
    @(negedge clk); pre_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (i != 0) @(negedge clk);
      in_en = 1'b1;
    end
    idle(3);
    chk("R5 cascade 60/3.0", cnt_main, 20);
    chk("R9 fixed pre /3 then /2", cnt_fix, 10);

    // R6: bypass then re-enable restarts the pre phase
    cur_req = "R6";
    pre_en = 1'b0; idle(2); cnt_main = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); in_en = 1'b1; end
    idle(3);
    chk("R6 bypass count 16/2.0", cnt_main, 8);

    // R7: random field rewrites colliding with pulses
    cur_req = "R7";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      in_en = ($urandom % 4) != 0;
      if ($urandom % 9 == 0) main_reg = ($urandom % 24) << 8;
      if ($urandom % 11 == 0) pre_reg = ($urandom % 12) << 4;
      if ($urandom % 17 == 0) pre_en = ~pre_en;
    end
    idle(3);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule